// File: doc/BRIEF.md
# Full-Period Shift-Register Sequence Generator

This block produces a pseudo-random bit sequence from a Fibonacci linear feedback shift register whose feedback is adjusted so that the all-zero state is part of the cycle. A plain maximal-length register of W stages walks 2^W - 1 states and sticks forever if it ever reaches all zeros. Here, a NOR of every stage except the outgoing one is XORed into the tap feedback. That one extra term splices the all-zero state in between the state with only the top bit set and the state with only the bottom bit set. The register therefore walks every one of the 2^W states exactly once per period. With the default width of 8 the cycle is 256 steps long.

The register advances by one position on each clock in which the step enable is high. A load strobe replaces the contents with a value taken from the seed port. A synchronous reset restores a seed fixed by a parameter. Every W-bit value is a legal seed, zero included. The full state is visible at the output, and the bit leaving the top stage is provided as a serial stream that can serve as a keystream for a bias-free scrambler.

Top module: `debruijn_seq`

## Requirements
- R1: While rst_i is high at a rising clock edge, the state becomes the parameter SEED (default 8'h01) at that edge, whatever the other inputs are.
- R2: When rst_i is low and load_i is high at an edge, the state becomes seed_i at that edge, whether en_i is high or low.
- R3: When rst_i, load_i and en_i are all low at an edge, state_o and ser_o keep their values.
- R4: On an enabled step (rst_i low, load_i low, en_i high), every bit moves one place toward the MSB, so that new state[W-1:1] equals old state[W-2:0]. Bit 0 takes the XOR of the stages selected by the mask TAPS, XORed with the correction term of R5. The default mask is 8'hB8, which selects bits 7, 5, 4 and 3 and corresponds to x^8+x^6+x^5+x^4+1.
- R5: The correction term is the NOR of state bits W-2 down to 0. As a result, a step from 8'h80 gives 8'h00, and a step from 8'h00 gives 8'h01.
- R6: Starting from any state, zero included, 2^W enabled steps visit 2^W distinct states and bring the state back to its start value.
- R7: ser_o always equals state_o[W-1], which is the bit that leaves the register on the next step. Over one full period ser_o is 1 in exactly 2^(W-1) of the states visited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high, loads SEED |
| en_i | input | 1 | Advance the register by one step |
| load_i | input | 1 | Replace the state with seed_i |
| seed_i | input | W | Value written by load_i |
| state_o | output | W | Current register contents |
| ser_o | output | 1 | Serial stream, the outgoing top stage |

## Verification
The full-period walk is run from three starting points. A seed of 8'h01 starts the walk on the ordinary LFSR path. A seed of zero starts it in the spliced state, which is exactly where a register without the correction term would lock up. A seed of 8'hA5 starts it in the middle of the cycle. A missed or repeated state, a period of 255, or an unbalanced serial stream each separates a broken splice from a correct one. Single directed steps from 8'hB8, 8'h08, 8'h80 and 8'h00 separate a wrong tap mask from a wrong correction term. Hold, load-without-enable and reset-over-load patterns show that the control priority is correct.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int unsigned DBS_DEF_W = 8;
    // x^8 + x^6 + x^5 + x^4 + 1 as a stage mask (bits 7,5,4,3)
    localparam logic [7:0] DBS_DEF_TAPS = 8'hB8;
    localparam logic [7:0] DBS_DEF_SEED = 8'h01;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_RESET = 2'd3
    } dbs_op_e;

endpackage

// File: rtl/dbs_op_decode.sv
module dbs_op_decode
    import dbs_pkg::*;
(
    input  logic    rst_i,
    input  logic    load_i,
    input  logic    en_i,
    output dbs_op_e op_o
);

    // priority: reset, then load, then step
    always_comb begin
        if (rst_i) begin
            op_o = OP_RESET;
        end else if (load_i) begin
            op_o = OP_LOAD;
        end else if (en_i) begin
            op_o = OP_STEP;
        end else begin
            op_o = OP_HOLD;
        end
    end

endmodule

// File: rtl/dbs_tap_parity.sv
module dbs_tap_parity #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic [W-1:0] state_i,
    output logic         par_o
);

    logic [W-1:0] chain;

    // ripple the parity across the selected stages; synthesis balances it
    for (genvar g = 0; g < W; g++) begin : g_tap
        if (g == 0) begin : g_first
            assign chain[g] = TAPS[g] & state_i[g];
        end else begin : g_rest
            assign chain[g] = chain[g-1] ^ (TAPS[g] & state_i[g]);
        end
    end

    assign par_o = chain[W-1];

endmodule

// File: rtl/dbs_zero_nor.sv
module dbs_zero_nor #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] state_i,
    output logic         nor_o
);

    localparam int unsigned LOW_W = W - 1;

    logic [LOW_W-1:0] low_bits;

    // all stages except the outgoing top one
    assign low_bits = state_i[LOW_W-1:0];
    assign nor_o    = ~(|low_bits);

endmodule

// File: rtl/debruijn_seq.sv
module debruijn_seq
    import dbs_pkg::*;
#(
    parameter int unsigned  W    = DBS_DEF_W,
    parameter logic [W-1:0] TAPS = DBS_DEF_TAPS,
    parameter logic [W-1:0] SEED = DBS_DEF_SEED
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         en_i,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    output logic [W-1:0] state_o,
    output logic         ser_o
);

    localparam int unsigned MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] sr;
    } dbs_regs_t;

    dbs_regs_t regs_d;
    dbs_regs_t regs_q;
    dbs_op_e   op;
    logic      tap_par;
    logic      zero_fix;
    logic      fb_bit;

    dbs_op_decode u_dec (
        .rst_i  (rst_i),
        .load_i (load_i),
        .en_i   (en_i),
        .op_o   (op)
    );

    dbs_tap_parity #(
        .W    (W),
        .TAPS (TAPS)
    ) u_par (
        .state_i (regs_q.sr),
        .par_o   (tap_par)
    );

    dbs_zero_nor #(
        .W (W)
    ) u_nor (
        .state_i (regs_q.sr),
        .nor_o   (zero_fix)
    );

    // one wide NOR feeding the same XOR as the taps
    assign fb_bit = tap_par ^ zero_fix;

    always_comb begin
        regs_d = regs_q;
        unique case (op)
            OP_RESET: regs_d.sr = SEED;
            OP_LOAD:  regs_d.sr = seed_i;
            OP_STEP:  regs_d.sr = {regs_q.sr[MSB-1:0], fb_bit};
            default:  regs_d.sr = regs_q.sr;
        endcase
    end

    always_ff @(posedge clk_i) begin
        regs_q <= regs_d;
    end

    assign state_o = regs_q.sr;
    assign ser_o   = regs_q.sr[MSB];

endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
    parameter int unsigned  W    = 8,
    parameter logic [W-1:0] SEED = 8'h01
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic         en_i,
    input logic         load_i,
    input logic [W-1:0] seed_i,
    input logic [W-1:0] state_o,
    input logic         ser_o
);

    localparam logic [W-1:0] TOP_ONLY = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic seen_q = 1'b0;
    always_ff @(posedge clk_i) seen_q <= 1'b1;

    logic step;
    assign step = !rst_i && !load_i && en_i;

    a_r1_reset_seed: assert property (@(posedge clk_i) disable iff (!seen_q)
        $past(rst_i) |-> state_o == SEED);

    a_r2_load_seed: assert property (@(posedge clk_i) disable iff (rst_i || !seen_q)
        load_i |=> state_o == $past(seed_i));

    a_r3_hold: assert property (@(posedge clk_i) disable iff (rst_i || !seen_q)
        (!load_i && !en_i) |=> ($stable(state_o) && $stable(ser_o)));

    a_r4_shift: assert property (@(posedge clk_i) disable iff (rst_i || !seen_q)
        step |=> state_o[W-1:1] == $past(state_o[W-2:0]));

    a_r5_enter_zero: assert property (@(posedge clk_i) disable iff (rst_i || !seen_q)
        (step && state_o == TOP_ONLY) |=> state_o == '0);

    a_r5_leave_zero: assert property (@(posedge clk_i) disable iff (rst_i || !seen_q)
        (step && state_o == '0) |=> state_o == ONE);

    a_r7_serial_msb: assert property (@(posedge clk_i) disable iff (!seen_q)
        ser_o == state_o[W-1]);

endmodule

bind debruijn_seq dbs_checker #(.W(W), .SEED(SEED)) u_dbs_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .en_i    (en_i),
    .load_i  (load_i),
    .seed_i  (seed_i),
    .state_o (state_o),
    .ser_o   (ser_o)
);

// File: tb/test_debruijn_seq.sv
module test_debruijn_seq;

    localparam int unsigned W          = 8;
    localparam int unsigned PERIOD     = 1 << W;
    localparam int          CLK_PERIOD = 10;
    localparam logic [W-1:0] SEED      = 8'h01;
    localparam logic [W-1:0] TAPS      = 8'hB8;

    logic         clk = 1'b0;
    logic         rst_i = 1'b1;
    logic         en_i = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] seed_i = '0;
    logic [W-1:0] state_o;
    logic         ser_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    debruijn_seq #(.W(W), .TAPS(TAPS), .SEED(SEED)) i_debruijn_seq (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .en_i    (en_i),
        .load_i  (load_i),
        .seed_i  (seed_i),
        .state_o (state_o),
        .ser_o   (ser_o)
    );

    // inputs change 1 time unit after an edge; outputs are read there too
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected next value from R4/R5
    function automatic logic [W-1:0] ref_step(input logic [W-1:0] s);
        logic fb;
        fb = ^(s & TAPS);
        fb = fb ^ (s[W-2:0] == '0);
        return {s[W-2:0], fb};
    endfunction

    task automatic load_value(input logic [W-1:0] v);
        load_i = 1'b1; seed_i = v; en_i = 1'b0;
        tick();
        load_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_i = 1'b1; load_i = 1'b1; en_i = 1'b1; seed_i = 8'hEE;
        tick();
        check("R1 reset beats load and step", state_o, SEED);
        check("R7 serial after reset", ser_o, SEED[W-1]);
        rst_i = 1'b0; load_i = 1'b0; en_i = 1'b0;
    endtask

    task automatic t_load();
        load_i = 1'b1; en_i = 1'b0; seed_i = 8'h5C;
        tick();
        check("R2 load without enable", state_o, 8'h5C);
        en_i = 1'b1; seed_i = 8'h93;
        tick();
        check("R2 load with enable", state_o, 8'h93);
        check("R7 serial after load", ser_o, 1'b1);
        load_i = 1'b0; en_i = 1'b0;
    endtask

    task automatic t_hold();
        load_value(8'hC3);
        en_i = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        check("R3 state holds", state_o, 8'hC3);
        check("R3 serial holds", ser_o, 1'b1);
    endtask

    task automatic t_step();
        load_value(8'hB8);
        en_i = 1'b1; tick(); en_i = 1'b0;
        check("R4 four taps set", state_o, 8'h70);
        load_value(8'h08);
        en_i = 1'b1; tick(); en_i = 1'b0;
        check("R4 single tap set", state_o, 8'h11);
        load_value(8'h01);
        en_i = 1'b1; tick(); en_i = 1'b0;
        check("R4 no tap set", state_o, 8'h02);
    endtask

    task automatic t_splice();
        load_value(8'h80);
        en_i = 1'b1; tick();
        check("R5 top-only enters zero", state_o, 8'h00);
        tick();
        check("R5 zero exits to one", state_o, 8'h01);
        en_i = 1'b0;
    endtask

    task automatic t_period(input logic [W-1:0] start);
        logic [PERIOD-1:0] seen;
        int repeats;
        int ones;
        int ser_err;
        int model_err;
        logic [W-1:0] prev;
        seen = '0; repeats = 0; ones = 0; ser_err = 0; model_err = 0;
        load_value(start);
        en_i = 1'b1;
        for (int i = 0; i < PERIOD; i++) begin
            if (seen[state_o]) repeats++;
            seen[state_o] = 1'b1;
            if (ser_o !== state_o[W-1]) ser_err++;
            if (ser_o === 1'b1) ones++;
            prev = state_o;
            tick();
            if (state_o !== ref_step(prev)) model_err++;
        end
        en_i = 1'b0;
        check("R6 no repeat within period", repeats, 0);
        check("R6 all states visited", $countones(seen), PERIOD);
        check("R6 back to start", state_o, start);
        check("R4 every step matches", model_err, 0);
        check("R7 serial is top stage", ser_err, 0);
        check("R7 ones per period", ones, PERIOD/2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        tick();
        t_reset();
        t_load();
        t_hold();
        t_step();
        t_splice();
        t_period(8'h01);
        t_period(8'h00);
        t_period(8'hA5);
        finish_run();
    end

endmodule